// File: doc/BRIEF.md
# Interrupt Status and Notification Unit

This block keeps a register of pending interrupt causes and turns it into a notification for a host. Software can set cause bits directly by writing a raise register, and clears them by writing an acknowledge register with a mask of the bits it has handled. Other blocks on the chip, such as a computation engine or a DMA engine, set their own cause bits through single-cycle request inputs. Each request input maps to a fixed status bit chosen by a parameter.

The notification has two forms, and an input picks between them. In level mode, which is the default when the mode input is low, a line stays high while any status bit is set. In message mode the line stays low. Instead, a one-cycle pulse is raised whenever a set event adds bits that were not already pending, and the message logic elsewhere turns it into a bus write. Software must acknowledge in both modes, because the status bits are only ever cleared by acknowledge writes.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status register is zero, `irq_line` is low and `msi_pulse` is low.
- R2: With `rd_addr` at the status offset (0x24), `rd_data` returns the current status bits.
- R3: With `rd_addr` at the raise offset (0x60) or the acknowledge offset (0x64), `rd_data` is zero.
- R4: A write to the raise offset ORs `wr_data` into status on the clock edge that accepts it. Bits already set stay set.
- R5: A write to the acknowledge offset clears every status bit that is 1 in `wr_data`. Every other bit is left unchanged.
- R6: A one-cycle pulse on `hw_req[i]` sets the status bit at position `HW_POS[i]`. The default mapping is bit 0 for source 0 and bit 8 for source 1.
- R7: When a hardware request and an acknowledge of the same bit happen in the same cycle, the bit ends up set.
- R8: With `msi_mode` low, `irq_line` is high exactly while status is nonzero, and it stays high until acknowledges bring status to zero.
- R9: With `msi_mode` high, `irq_line` is low. `msi_pulse` is high for one cycle, in the cycle after a set event, only if that event added at least one bit that was not already set.
- R10: A write to any offset other than raise or acknowledge, including the read-only status offset, leaves status unchanged.
- R11: In message mode, acknowledge writes clear status bits in the same way as in level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_mode | input | 1 | 0: level line, 1: message pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Combinational read data |
| hw_req | input | HW_SRC_N | Hardware set requests, one per source |
| irq_line | output | 1 | Level interrupt line |
| msi_pulse | output | 1 | One-cycle message interrupt request |

## Verification
A hardware set request and a software acknowledge can land in the same cycle and target the same bit. The bench provokes this by driving `hw_req[0]` in the cycle that writes an acknowledge mask covering bits 0 and 8. It passes only if bit 0 reads back as set and bit 8 reads back as cleared. In message mode the bench also repeats a raise of a bit that is already pending and judges that no pulse follows, then raises a mask that mixes an old bit with a new one and expects exactly one pulse.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
   // decoded kind of a register write
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_RAISE = 2'd1,
      ACC_ACK   = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/irq_acc_decode.sv
module irq_acc_decode
   import irq_unit_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned RAISE_OFS = 'h60,
   parameter int unsigned ACK_OFS   = 'h64
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output acc_kind_e         kind
);
   localparam logic [ADDR_W-1:0] RAISE_A = ADDR_W'(RAISE_OFS);
   localparam logic [ADDR_W-1:0] ACK_A   = ADDR_W'(ACK_OFS);

   always_comb begin
      kind = ACC_NONE;
      if (wr_en) begin
         if (wr_addr == RAISE_A)    kind = ACC_RAISE;
         else if (wr_addr == ACK_A) kind = ACC_ACK;
      end
   end
endmodule

// File: rtl/irq_hw_map.sv
module irq_hw_map #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned HW_SRC_N = 2,
   parameter int unsigned HW_POS [HW_SRC_N] = '{0, 8}
) (
   input  logic [HW_SRC_N-1:0] hw_req,
   output logic [DATA_W-1:0]   hw_vec
);
   logic [DATA_W-1:0] part [HW_SRC_N];

   for (genvar i = 0; i < HW_SRC_N; i++) begin : g_src
      if (HW_POS[i] >= DATA_W) begin : g_bad
         $error("hardware source bit position outside status width");
      end
      assign part[i] = hw_req[i] ? (DATA_W'(1) << HW_POS[i]) : '0;
   end

   always_comb begin
      hw_vec = '0;
      for (int k = 0; k < HW_SRC_N; k++) hw_vec |= part[k];
   end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_vec,
   input  logic [DATA_W-1:0] clr_vec,
   output logic [DATA_W-1:0] status,
   output logic              adds_new
);
   // set wins over clear for the bits it names
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr_vec) | set_vec;
   end

   assign adds_new = |(set_vec & ~status);
endmodule

// File: rtl/irq_notify.sv
module irq_notify #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msi_mode,
   input  logic [DATA_W-1:0] status,
   input  logic              adds_new,
   output logic              irq_line,
   output logic              msi_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msi_pulse <= 1'b0;
      else        msi_pulse <= msi_mode && adds_new;
   end

   assign irq_line = !msi_mode && (|status);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
   import irq_unit_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned STATUS_OFS = 'h24,
   parameter int unsigned RAISE_OFS  = 'h60,
   parameter int unsigned ACK_OFS    = 'h64,
   parameter int unsigned HW_SRC_N   = 2,
   parameter int unsigned HW_POS [HW_SRC_N] = '{0, 8}
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                msi_mode,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   input  logic [HW_SRC_N-1:0] hw_req,
   output logic                irq_line,
   output logic                msi_pulse
);
   localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);

   if (STATUS_OFS >= (1 << ADDR_W) || RAISE_OFS >= (1 << ADDR_W) ||
       ACK_OFS >= (1 << ADDR_W)) begin : g_ofs_bad
      $error("register offset does not fit the address width");
   end
   if (RAISE_OFS == ACK_OFS || STATUS_OFS == RAISE_OFS ||
       STATUS_OFS == ACK_OFS) begin : g_ofs_clash
      $error("register offsets must be distinct");
   end

   acc_kind_e         kind;
   logic [DATA_W-1:0] hw_vec;
   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] clr_vec;
   logic [DATA_W-1:0] status_q;
   logic              adds_new;

   irq_acc_decode #(
      .ADDR_W(ADDR_W), .RAISE_OFS(RAISE_OFS), .ACK_OFS(ACK_OFS)
   ) dec_i (
      .wr_en(wr_en), .wr_addr(wr_addr), .kind(kind)
   );

   irq_hw_map #(
      .DATA_W(DATA_W), .HW_SRC_N(HW_SRC_N), .HW_POS(HW_POS)
   ) map_i (
      .hw_req(hw_req), .hw_vec(hw_vec)
   );

   assign set_vec = hw_vec | ((kind == ACC_RAISE) ? wr_data : '0);
   assign clr_vec = (kind == ACC_ACK) ? wr_data : '0;

   irq_status_reg #(.DATA_W(DATA_W)) st_i (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
      .status(status_q), .adds_new(adds_new)
   );

   irq_notify #(.DATA_W(DATA_W)) ntf_i (
      .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .status(status_q),
      .adds_new(adds_new), .irq_line(irq_line), .msi_pulse(msi_pulse)
   );

   // write-only and unmapped offsets read as zero
   assign rd_data = (rd_addr == STATUS_A) ? status_q : '0;
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned RAISE_OFS = 'h60,
   parameter int unsigned ACK_OFS   = 'h64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              msi_mode,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] status,
   input logic [DATA_W-1:0] hw_vec,
   input logic              irq_line,
   input logic              msi_pulse
);
   localparam logic [ADDR_W-1:0] RAISE_A = ADDR_W'(RAISE_OFS);
   localparam logic [ADDR_W-1:0] ACK_A   = ADDR_W'(ACK_OFS);

   AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == RAISE_A) |=> ((status & $past(wr_data)) == $past(wr_data))); // R4

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ACK_A) |=> ((status & $past(wr_data) & ~$past(hw_vec)) == '0)); // R5

   AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_vec) |=> ((status & $past(hw_vec)) == $past(hw_vec))); // R7

   AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      msi_pulse |-> ($past(msi_mode) && ((status & ~$past(status)) != '0))); // R9

   AST_LINE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irq_line) && !msi_mode && !$past(msi_mode)) |-> (status == '0)); // R8
endmodule

bind irq_status_unit irq_unit_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RAISE_OFS(RAISE_OFS), .ACK_OFS(ACK_OFS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .wr_en(wr_en),
   .wr_addr(wr_addr), .wr_data(wr_data), .status(status_q), .hw_vec(hw_vec),
   .irq_line(irq_line), .msi_pulse(msi_pulse)
);

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;
   localparam int DW = 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          msi_mode = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = 8'h24;
   logic [DW-1:0] rd_data;
   logic [1:0]    hw_req = '0;
   logic          irq_line;
   logic          msi_pulse;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_status_unit dut_i (
      .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .hw_req(hw_req), .irq_line(irq_line),
      .msi_pulse(msi_pulse)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd_status(input string tag, input logic [DW-1:0] exp);
      rd_addr = 8'h24;
      #1;
      check(tag, rd_data, exp);
   endtask

   // drive at a falling edge, release at the next falling edge (after one rising edge)
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] hw);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; hw_req = hw;
      @(negedge clk);
      wr_en = 1'b0; hw_req = '0;
   endtask

   task automatic t_reset();
      rd_status("R1 status after reset", '0);
      check("R1 line after reset", {31'b0, irq_line}, 0);
      check("R1 pulse after reset", {31'b0, msi_pulse}, 0);
   endtask

   task automatic t_raise();
      wr(8'h60, 32'h11, 2'b00);
      rd_status("R4 R2 raise sets bits", 32'h11);
      check("R8 line high", {31'b0, irq_line}, 1);
      wr(8'h60, 32'h100, 2'b00);
      rd_status("R4 raise ORs", 32'h111);
   endtask

   task automatic t_wo_read();
      rd_addr = 8'h60; #1;
      check("R3 raise offset reads zero", rd_data, '0);
      rd_addr = 8'h64; #1;
      check("R3 ack offset reads zero", rd_data, '0);
   endtask

   task automatic t_other();
      wr(8'h28, 32'hFFFF, 2'b00);
      rd_status("R10 unmapped write ignored", 32'h111);
      wr(8'h24, 32'hFF, 2'b00);
      rd_status("R10 status offset write ignored", 32'h111);
   endtask

   task automatic t_ack();
      wr(8'h64, 32'h11, 2'b00);
      rd_status("R5 partial ack", 32'h100);
      check("R8 line held while nonzero", {31'b0, irq_line}, 1);
      wr(8'h64, 32'h100, 2'b00);
      rd_status("R5 final ack", '0);
      check("R8 line drops at zero", {31'b0, irq_line}, 0);
   endtask

   task automatic t_hw();
      wr(8'h00, '0, 2'b10);
      rd_status("R6 source 1 sets bit 8", 32'h100);
      wr(8'h00, '0, 2'b01);
      rd_status("R6 source 0 sets bit 0", 32'h101);
   endtask

   task automatic t_collide();
      wr(8'h64, 32'h101, 2'b01);
      rd_status("R7 hw set beats ack", 32'h001);
      wr(8'h64, 32'h1, 2'b00);
      rd_status("R7 cleanup", '0);
   endtask

   task automatic t_msi();
      @(negedge clk); msi_mode = 1'b1;
      wr(8'h60, 32'h4, 2'b00);
      check("R9 pulse after new bit", {31'b0, msi_pulse}, 1);
      check("R9 line low in msi", {31'b0, irq_line}, 0);
      @(negedge clk);
      check("R9 pulse one cycle", {31'b0, msi_pulse}, 0);
      wr(8'h60, 32'h4, 2'b00);
      check("R9 no pulse for pending bit", {31'b0, msi_pulse}, 0);
      wr(8'h60, 32'h6, 2'b00);
      check("R9 pulse for mixed mask", {31'b0, msi_pulse}, 1);
      wr(8'h64, 32'h6, 2'b00);
      rd_status("R11 ack clears in msi", '0);
      check("R11 no pulse on ack", {31'b0, msi_pulse}, 0);
      wr(8'h00, '0, 2'b01);
      check("R9 hw pulse in msi", {31'b0, msi_pulse}, 1);
      @(negedge clk); msi_mode = 1'b0; #1;
      check("R8 line after leaving msi", {31'b0, irq_line}, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_raise();
      t_wo_read();
      t_other();
      t_ack();
      t_hw();
      t_collide();
      t_msi();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule